// File: doc/BRIEF.md
# Serial-Load Dot-Line Drive Level Selector

This block is the digital front of a dot-matrix display line driver. Display bits arrive one at a time on a serial input and move along a chain of `N_OUT` stages. The chain advances on the falling edge of a separate shift clock. That clock is sampled by the system clock, so the chain advances one system clock after the edge is seen. The last stage is brought out as a cascade output, so several drivers can be chained to cover a wider panel.

A level-controlled hold stage sits between the chain and the outputs. While the load input is high, the hold stage follows the chain. While it is low, the hold stage keeps its last captured value. Each held bit is turned into a 2-bit drive-level code for its output. The code depends on the held bit, the frame alternation input and the row/column role select. The codes are 00 for the top rail (VDD), 01 for V2, 10 for V3 and 11 for the bottom rail (V5).

In the row (common) role, the load input is normally tied high, so the hold stage is in effect transparent. The alternation input and the role select act on the codes combinationally.

Top module: `dotline_drive`

## Requirements
- R1: After the active-low asynchronous reset, every chain stage and every held bit is 0 and the cascade output is 0. Every output therefore carries a non-select code: 01 when alternation is low, 10 when it is high.
- R2: The chain advances only on a falling edge of `shift_clk`, one system clock after that edge is sampled. A rising edge, or a steady level held for any number of clocks, leaves the chain unchanged.
- R3: A bit on `ser_in` enters stage 1 on a shift. After exactly `N_OUT` shifts it drives `cascade_out`, and no earlier.
- R4: While `load_en` is high, the hold stage takes the chain value at every system clock, so the outputs follow the chain one clock later.
- R5: While `load_en` is low, the held bits and all output codes stay fixed even as the chain keeps shifting.
- R6: Row role (`row_mode`=1), held bit 1: the code is 00 (VDD) when `alt_phase`=1 and 11 (V5) when `alt_phase`=0.
- R7: Column role (`row_mode`=0), held bit 1: the code is 11 (V5) when `alt_phase`=1 and 00 (VDD) when `alt_phase`=0.
- R8: Held bit 0, in either role: the code is 10 (V3) when `alt_phase`=1 and 01 (V2) when `alt_phase`=0. A select rail (00 or 11) is never produced for a 0 bit.
- R9: A change on `alt_phase` or `row_mode` reaches the codes in the same cycle, with no shift or load event needed.
- R10: Output k (1-based) takes its code from stage k of the chain and sits in `drive_code[2k-1:2k-2]`. Stage 1 is the stage most recently written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples the shift clock and updates the hold stage |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_in | input | 1 | Serial display data |
| shift_clk | input | 1 | Shift clock; the chain advances on its falling edge |
| load_en | input | 1 | High: hold stage follows the chain; low: hold stage keeps its value |
| alt_phase | input | 1 | Frame alternation signal |
| row_mode | input | 1 | 1 = row (common) role, 0 = column (segment) role |
| cascade_out | output | 1 | Last chain stage, for chaining drivers |
| drive_code | output | 2*N_OUT | Packed 2-bit level code per output |

## Verification
The bench drives rising-only and steady shift-clock stretches. A design that acts on the wrong edge, or shifts on level, shows a moved bit pattern there. A lone 1 is walked to the cascade tap and checked at shift 79 and at shift 80, which exposes a chain one stage too short or too long. Load is dropped while shifting continues, so a hold stage that leaks shows changed codes. All four alternation/role combinations are swept with no clock in between. This catches swapped select rails in the column role, a 0 bit that picks a select rail, and a decode that waits for a clock before responding.

// File: rtl/dotline_pkg.sv
package dotline_pkg;

   typedef enum logic [1:0] {
      LV_TOP  = 2'b00,
      LV_UPMID = 2'b01,
      LV_LOMID = 2'b10,
      LV_BOT  = 2'b11
   } level_t;

   function automatic level_t pick_level(input logic bit_on,
                                         input logic alt,
                                         input logic row_role);
      level_t r;
      if (!bit_on)
         r = alt ? LV_LOMID : LV_UPMID;
      else if (row_role)
         r = alt ? LV_TOP : LV_BOT;
      else
         r = alt ? LV_BOT : LV_TOP;
      return r;
   endfunction

endpackage

// File: rtl/dotline_shift_chain.sv
module dotline_shift_chain #(
   parameter int N_STAGE   = 80,
   parameter bit FALL_EDGE = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               din,
   input  logic               sck,
   output logic [N_STAGE-1:0] stages,
   output logic               tap
);
   localparam int LAST = N_STAGE - 1;

   if (N_STAGE < 2) begin : g_bad_len
      $error("dotline_shift_chain: N_STAGE must be at least 2");
   end

   logic sck_q;
   logic fire;
   logic [N_STAGE-1:0] sr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sck_q <= 1'b0;
      else        sck_q <= sck;
   end

   generate
      if (FALL_EDGE) begin : g_fall
         assign fire = sck_q & ~sck;
      end else begin : g_rise
         assign fire = ~sck_q & sck;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    sr <= '0;
      else if (fire) sr <= {sr[LAST-1:0], din};
   end

   assign stages = sr;
   assign tap    = sr[LAST];

   // R2
   no_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !fire |=> $stable(sr));

   // R3
   entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> (sr[0] == $past(din)));

   // R3
   cascade_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> (tap == $past(sr[LAST-1])));

endmodule

// File: rtl/dotline_hold_stage.sv
module dotline_hold_stage #(
   parameter int N_BIT = 80
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [N_BIT-1:0] d,
   output logic [N_BIT-1:0] q
);
   if (N_BIT < 1) begin : g_bad_width
      $error("dotline_hold_stage: N_BIT must be positive");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= '0;
      else if (load) q <= d;
   end

   // R5
   hold_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(q));

   // R4
   follow_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (q == $past(d)));

endmodule

// File: rtl/dotline_level_dec.sv
module dotline_level_dec
   import dotline_pkg::*;
#(
   parameter int N_OUT = 80
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_OUT-1:0]   held,
   input  logic               alt,
   input  logic               row_role,
   output logic [2*N_OUT-1:0] codes
);
   localparam int CW = 2;

   if (N_OUT < 1) begin : g_bad_cnt
      $error("dotline_level_dec: N_OUT must be positive");
   end

   genvar i;
   generate
      for (i = 0; i < N_OUT; i++) begin : g_out
         level_t lv;
         always_comb lv = pick_level(held[i], alt, row_role);
         assign codes[CW*i +: CW] = lv;

         // R8
         nonsel_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !held[i] |-> (codes[CW*i+1] != codes[CW*i]));
      end
   endgenerate

endmodule

// File: rtl/dotline_drive.sv
module dotline_drive #(
   parameter int N_OUT     = 80,
   parameter bit FALL_EDGE = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ser_in,
   input  logic               shift_clk,
   input  logic               load_en,
   input  logic               alt_phase,
   input  logic               row_mode,
   output logic               cascade_out,
   output logic [2*N_OUT-1:0] drive_code
);
   if (N_OUT < 2) begin : g_bad_top
      $error("dotline_drive: N_OUT must be at least 2");
   end

   logic [N_OUT-1:0] chain_q;
   logic [N_OUT-1:0] held_q;

   dotline_shift_chain #(
      .N_STAGE   (N_OUT),
      .FALL_EDGE (FALL_EDGE)
   ) u_chain (
      .clk    (clk),
      .rst_n  (rst_n),
      .din    (ser_in),
      .sck    (shift_clk),
      .stages (chain_q),
      .tap    (cascade_out)
   );

   dotline_hold_stage #(
      .N_BIT (N_OUT)
   ) u_hold (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (load_en),
      .d     (chain_q),
      .q     (held_q)
   );

   dotline_level_dec #(
      .N_OUT (N_OUT)
   ) u_dec (
      .clk      (clk),
      .rst_n    (rst_n),
      .held     (held_q),
      .alt      (alt_phase),
      .row_role (row_mode),
      .codes    (drive_code)
   );

   // R5
   out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_en && $stable(alt_phase) && $stable(row_mode)) |=>
      ($stable(drive_code) || $changed(alt_phase) || $changed(row_mode)));

endmodule

// File: tb/dotline_drive_bench.sv
module dotline_drive_bench;
   localparam int CLK_PERIOD = 10;
   localparam int N = 80;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ser_in = 1'b0;
   logic shift_clk = 1'b0;
   logic load_en = 1'b1;
   logic alt_phase = 1'b0;
   logic row_mode = 1'b1;
   logic cascade_out;
   logic [2*N-1:0] drive_code;

   int n_run = 0;
   int n_fail = 0;
   logic [N-1:0] m_sr = '0;
   logic [N-1:0] m_lat = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dotline_drive #(.N_OUT(N)) u_dotline_drive (
      .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .shift_clk(shift_clk),
      .load_en(load_en), .alt_phase(alt_phase), .row_mode(row_mode),
      .cascade_out(cascade_out), .drive_code(drive_code)
   );

   function automatic logic [1:0] exp_code(logic b, logic a, logic r);
      if (!b) return a ? 2'b10 : 2'b01;
      if (r)  return a ? 2'b00 : 2'b11;
      return a ? 2'b11 : 2'b00;
   endfunction

   function automatic logic [2*N-1:0] exp_bus(logic [N-1:0] l, logic a, logic r);
      logic [2*N-1:0] v;
      for (int k = 0; k < N; k++) v[2*k +: 2] = exp_code(l[k], a, r);
      return v;
   endfunction

   task automatic chk_bus(string req);
      logic [2*N-1:0] e;
      e = exp_bus(m_lat, alt_phase, row_mode);
      n_run++;
      if (drive_code !== e) begin
         n_fail++;
         for (int k = 0; k < N; k++)
            if (drive_code[2*k +: 2] !== e[2*k +: 2]) begin
               $display("FAIL %s output %0d: got %b expected %b", req, k+1,
                        drive_code[2*k +: 2], e[2*k +: 2]);
               break;
            end
      end
   endtask

   task automatic chk_cas(string req, logic e);
      n_run++;
      if (cascade_out !== e) begin
         n_fail++;
         $display("FAIL %s cascade: got %b expected %b", req, cascade_out, e);
      end
   endtask

   // one falling edge of shift_clk; returns at a negedge with the hold stage settled
   task automatic shift_bit(logic b);
      ser_in = b; shift_clk = 1'b1;
      @(negedge clk);
      shift_clk = 1'b0;
      @(negedge clk);
      @(negedge clk);
      m_sr = {m_sr[N-2:0], b};
      if (load_en) m_lat = m_sr;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      // R1: reset state
      chk_bus("R1"); chk_cas("R1", 1'b0);
      alt_phase = 1'b1; #1; chk_bus("R1");
      rst_n = 1'b1;
      @(negedge clk); alt_phase = 1'b0;

      // R2: rising edge and steady levels never shift
      ser_in = 1'b1; shift_clk = 1'b1;
      repeat (5) @(negedge clk);
      chk_bus("R2"); chk_cas("R2", 1'b0);
      shift_clk = 1'b0;
      repeat (2) @(negedge clk);   // this falling edge does shift
      m_sr = {m_sr[N-2:0], 1'b1}; m_lat = m_sr;
      repeat (5) @(negedge clk);
      chk_bus("R2");

      // R3 / R10: lone 1 walked to the cascade tap
      for (int k = 0; k < N; k++) shift_bit(1'b0);
      shift_bit(1'b1);
      chk_bus("R10");
      for (int k = 1; k < N; k++) begin
         if (k == N-1) chk_cas("R3", 1'b0);
         shift_bit(1'b0);
      end
      chk_cas("R3", 1'b1);
      chk_bus("R10");

      // R4: random fill with load high
      for (int k = 0; k < N; k++) begin
         shift_bit(1'($urandom));
         chk_bus("R4"); chk_cas("R3", m_sr[N-1]);
      end

      // R5: hold with load low while shifting continues
      load_en = 1'b0;
      for (int k = 0; k < 12; k++) begin
         shift_bit(1'($urandom));
         chk_bus("R5"); chk_cas("R3", m_sr[N-1]);
      end
      load_en = 1'b1;
      @(negedge clk); m_lat = m_sr; chk_bus("R4");

      // R6 R7 R8 R9: combinational sweep with no clock edge in between
      @(posedge clk); #1;
      for (int c = 0; c < 4; c++) begin
         row_mode = c[1]; alt_phase = c[0];
         #1;
         chk_bus(c[1] ? "R6" : "R7");
         chk_bus("R9");
      end
      m_lat = '0;
      load_en = 1'b1;
      for (int k = 0; k < N; k++) shift_bit(1'b0);
      for (int c = 0; c < 4; c++) begin
         row_mode = c[1]; alt_phase = c[0]; #1; chk_bus("R8");
      end

      // mixed random
      for (int k = 0; k < 150; k++) begin
         @(negedge clk);
         load_en = 1'($urandom); alt_phase = 1'($urandom); row_mode = 1'($urandom);
         shift_bit(1'($urandom));
         chk_bus(load_en ? "R4" : "R5");
         chk_cas("R3", m_sr[N-1]);
      end

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule